// File: doc/BRIEF.md
# Scrambled-Link Detect Qualifier and Transmitter-Off Timer

This block sits beside the scrambler of a serial physical-layer path and owns one 16-bit control word on a simple register bus. The word selects whether scrambling is on, whether the scrambler output is looped into the descrambler, and how two timed outputs behave. The first timed output is a qualified line-detect signal. It is derived from the raw detect input by holding off the rising and the falling edges for programmable times. The hold-off on the rising edge gives the descrambler time to lock. The second timed output switches the optical transmitter off once quiet symbols have been sent, scrambled, for a programmable time.

A strap input sets the power-up state of scrambling and forces it on while the strap is high. The timed behaviour applies only while scrambling is active. Otherwise the detect output copies the raw input one cycle later, and the transmitter-off output copies the quiet-status input. All delays are counted on a 40 ns symbol clock. The cycle counts are derived from that period.

Top module: `scrq_top`

## Requirements
- R1: A synchronous active-low reset clears every bit of the control word except bit 0. Bit 0 takes the level of `strap_scr` during reset. After reset, `det_qual`, `loop_sel` and `tx_off` are 0 while `raw_det` and `quiet_tx` are 0.
- R2: A write to bus address 0x0A stores bits 13:6, 1 and 0 of `bus_wdata`. A read at 0x0A returns the word on `bus_rdata` in the same cycle. A read at any other address returns 0.
- R3: Bits 15:14 and 5:2 always read as 0, whatever was written.
- R4: While `strap_scr` is high, bit 0 is set to 1 on every clock edge, so it reads 1 even after a write of 0. `scr_active` is high whenever `strap_scr` or bit 0 is high. While the strap is low, bit 0 keeps the last value written to it.
- R5: `loop_sel` equals bit 1 of the word.
- R6: When scrambling is inactive, or when the enable for the pending edge is clear, `det_qual` copies `raw_det` at the next clock edge. Bit 7 enables the rising-edge hold-off and bit 6 enables the falling-edge hold-off.
- R7: When scrambling is active and bit 7 is set, `det_qual` rises on the Nth consecutive clock edge at which `raw_det` is sampled high. N is chosen by bits 11:10: 00 gives 21, 01 gives 33, 10 gives 63 and 11 gives 128.
- R8: When scrambling is active and bit 6 is set, `det_qual` falls on the Nth consecutive clock edge at which `raw_det` is sampled low. N is chosen by bits 13:12: 00 gives 19, 01 gives 33, 10 gives 63 and 11 gives 128.
- R9: If `raw_det` returns to the level of `det_qual` before the hold-off ends, the count restarts and `det_qual` does not change.
- R10: While scrambling is active, bits 9:8 set the transmitter-off behaviour. With 00, `tx_off` equals `quiet_tx`. With 01 or 10, `tx_off` rises once `quiet_tx` has been sampled high on 750 or 1250 consecutive edges respectively. With 11, `tx_off` stays 0.
- R11: `tx_off` is never high while `quiet_tx` is low, so it drops in the same cycle that `quiet_tx` falls. While scrambling is inactive, `tx_off` equals `quiet_tx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_scr | input | 1 | Scramble strap; forces scrambling on |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| raw_det | input | 1 | Unqualified line-detect input |
| quiet_tx | input | 1 | High while quiet symbols are being sent |
| scr_active | output | 1 | Scrambler and descrambler enabled |
| loop_sel | output | 1 | Route scrambler output to the descrambler input |
| det_qual | output | 1 | Qualified line-detect output |
| tx_off | output | 1 | Optical transmitter off request |

## Verification
The embedded assertions check the following on every cycle:
- reserved read bits are zero;
- the strap forces bit 0 on;
- `det_qual` only ever moves toward the sampled raw level;
- `det_qual` copies `raw_det` one cycle later while scrambling is off;
- the hold-off counter stays in range;
- `tx_off` never rises without `quiet_tx`, and never rises under the never-assert code.

Only the directed scenarios can show that the exact hold-off lengths match each code. The same goes for the restart of a count after a short glitch, the 750- and 1250-cycle transmitter delays, and register readback after writes.

// File: rtl/scrq_pkg.sv
// Package: shared configuration type and delay-code to cycle-count helpers.
// Assumes all delays are whole multiples of the symbol clock period.
package scrq_pkg;

    typedef struct packed {
        logic [1:0] fall_sel;   // word bits 13:12
        logic [1:0] rise_sel;   // word bits 11:10
        logic [1:0] txo_sel;    // word bits 9:8
        logic       rise_en;    // word bit 7
        logic       fall_en;    // word bit 6
        logic       loop;       // word bit 1
        logic       scr_bit;    // word bit 0 (stored)
    } scrq_cfg_t;

    // Converts a delay in ns to symbol clock cycles, rounding up.
    function automatic int unsigned ns2cyc(int unsigned ns, int unsigned clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    // Rising-edge hold-off length for a code.
    function automatic int unsigned rise_cycles(logic [1:0] code, int unsigned clk_ns);
        case (code)
            2'b00:   return ns2cyc(840, clk_ns);
            2'b01:   return ns2cyc(1320, clk_ns);
            2'b10:   return ns2cyc(2520, clk_ns);
            default: return ns2cyc(5120, clk_ns);
        endcase
    endfunction

    // Falling-edge hold-off length for a code.
    function automatic int unsigned fall_cycles(logic [1:0] code, int unsigned clk_ns);
        case (code)
            2'b00:   return ns2cyc(760, clk_ns);
            2'b01:   return ns2cyc(1320, clk_ns);
            2'b10:   return ns2cyc(2520, clk_ns);
            default: return ns2cyc(5120, clk_ns);
        endcase
    endfunction

endpackage

// File: rtl/scrq_ctrl_reg.sv
// Control word register with strap-forced scramble bit.
// Assumes a single-cycle write strobe; reads are combinational.
module scrq_ctrl_reg
    import scrq_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 16,
    parameter logic [7:0]  REG_ADDR = 8'h0A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output scrq_cfg_t         cfg
);
    localparam logic [DATA_W-1:0] WMASK = DATA_W'(16'h3FC3);

    logic [DATA_W-1:0] word_q;
    logic              hit;

    assign hit = (addr == ADDR_W'(REG_ADDR));

    // Holds the word; bit 0 loads the strap on reset and is set while it is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q    <= '0;
            word_q[0] <= strap;
        end else begin
            if (wr && hit) word_q <= wdata & WMASK;
            if (strap)     word_q[0] <= 1'b1;
        end
    end

    // Read mux: the word at the register address, zero elsewhere.
    always_comb begin
        rdata = hit ? (word_q & WMASK) : '0;
    end

    // Unpacks the stored word into named fields.
    always_comb begin
        cfg.fall_sel = word_q[13:12];
        cfg.rise_sel = word_q[11:10];
        cfg.txo_sel  = word_q[9:8];
        cfg.rise_en  = word_q[7];
        cfg.fall_en  = word_q[6];
        cfg.loop     = word_q[1];
        cfg.scr_bit  = word_q[0];
    end

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[15:14] == 2'b00) && (rdata[5:2] == 4'b0000)); // R3
    AST_STRAP_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        strap |=> cfg.scr_bit); // R4
endmodule

// File: rtl/scrq_det_filter.sv
// Qualifies the raw detect input with separate rising and falling hold-offs.
// Assumes raw_det is already synchronous to clk.
module scrq_det_filter
    import scrq_pkg::*;
#(
    parameter int unsigned CLK_NS = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       rise_en,
    input  logic       fall_en,
    input  logic [1:0] rise_sel,
    input  logic [1:0] fall_sel,
    input  logic       raw,
    output logic       q
);
    localparam int unsigned MAXC = ns2cyc(5120, CLK_NS);
    localparam int         CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;
    logic          hold;

    // Picks the hold-off for the pending edge and whether it applies.
    always_comb begin
        if (!q) begin
            limit = CW'(rise_cycles(rise_sel, CLK_NS));
            hold  = active && rise_en;
        end else begin
            limit = CW'(fall_cycles(fall_sel, CLK_NS));
            hold  = active && fall_en;
        end
    end

    // Counts consecutive samples that differ from the output; moves the output at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= 1'b0;
            cnt_q <= '0;
        end else if (raw == q) begin
            cnt_q <= '0;
        end else if (!hold || (cnt_q >= limit - CW'(1))) begin
            q     <= raw;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    AST_Q_TOWARD_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (q != $past(q)) |-> (q == $past(raw))); // R9
    AST_PASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (q == $past(raw))); // R6
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(MAXC)); // R7
endmodule

// File: rtl/scrq_txoff_timer.sv
// Times the transmitter-off request from the start of quiet-symbol output.
// Assumes quiet_tx is synchronous to clk.
module scrq_txoff_timer
    import scrq_pkg::*;
#(
    parameter int unsigned CLK_NS = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic [1:0] sel,
    input  logic       quiet,
    output logic       tx_off
);
    localparam int unsigned SHORT_C = ns2cyc(30000, CLK_NS);
    localparam int unsigned LONG_C  = ns2cyc(50000, CLK_NS);
    localparam int          TW      = $clog2(LONG_C + 1);

    logic [TW-1:0] run_q;

    // Counts consecutive quiet samples, saturating at the longest delay.
    always_ff @(posedge clk) begin
        if (!rst_n || !quiet)       run_q <= '0;
        else if (run_q < TW'(LONG_C)) run_q <= run_q + TW'(1);
    end

    // Chooses the output for the selected delay code.
    always_comb begin
        if (!active) begin
            tx_off = quiet;
        end else begin
            case (sel)
                2'b00:   tx_off = quiet;
                2'b01:   tx_off = quiet && (run_q >= TW'(SHORT_C));
                2'b10:   tx_off = quiet && (run_q >= TW'(LONG_C));
                default: tx_off = 1'b0;
            endcase
        end
    end

    AST_TXOFF_NEEDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        tx_off |-> quiet); // R11
    AST_TXOFF_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
        (active && sel == 2'b11) |-> !tx_off); // R10
endmodule

// File: rtl/scrq_top.sv
// Top: control word, scramble enable, detect qualifier and transmitter-off timer.
// Assumes one clock domain with every input synchronous to it.
module scrq_top
    import scrq_pkg::*;
#(
    parameter int unsigned CLK_NS   = 40,
    parameter int          ADDR_W   = 8,
    parameter logic [7:0]  REG_ADDR = 8'h0A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_scr,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              raw_det,
    input  logic              quiet_tx,
    output logic              scr_active,
    output logic              loop_sel,
    output logic              det_qual,
    output logic              tx_off
);
    scrq_cfg_t cfg;

    scrq_ctrl_reg #(.ADDR_W(ADDR_W), .DATA_W(16), .REG_ADDR(REG_ADDR)) u_reg (
        .clk(clk), .rst_n(rst_n), .strap(strap_scr), .wr(bus_wr),
        .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata), .cfg(cfg)
    );

    // Scrambling runs when the strap or the stored bit asks for it.
    always_comb begin
        scr_active = strap_scr | cfg.scr_bit;
        loop_sel   = cfg.loop;
    end

    scrq_det_filter #(.CLK_NS(CLK_NS)) u_det (
        .clk(clk), .rst_n(rst_n), .active(scr_active),
        .rise_en(cfg.rise_en), .fall_en(cfg.fall_en),
        .rise_sel(cfg.rise_sel), .fall_sel(cfg.fall_sel),
        .raw(raw_det), .q(det_qual)
    );

    scrq_txoff_timer #(.CLK_NS(CLK_NS)) u_txo (
        .clk(clk), .rst_n(rst_n), .active(scr_active),
        .sel(cfg.txo_sel), .quiet(quiet_tx), .tx_off(tx_off)
    );

    AST_STRAP_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        strap_scr |-> scr_active); // R4
endmodule

// File: tb/scrq_top_test.sv
module scrq_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_scr = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h0A;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        raw_det = 1'b0;
    logic        quiet_tx = 1'b0;
    logic        scr_active, loop_sel, det_qual, tx_off;
    int          n_tests = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    scrq_top uut (
        .clk(clk), .rst_n(rst_n), .strap_scr(strap_scr), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .raw_det(raw_det), .quiet_tx(quiet_tx), .scr_active(scr_active),
        .loop_sel(loop_sel), .det_qual(det_qual), .tx_off(tx_off)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(logic strap);
        @(negedge clk);
        strap_scr = strap; rst_n = 1'b0; raw_det = 1'b0; quiet_tx = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_word(logic [15:0] d);
        bus_addr = 8'h0A; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(string req, logic [7:0] a, logic [15:0] exp);
        bus_addr = a;
        #1 check(req, bus_rdata, exp);
        bus_addr = 8'h0A;
    endtask

    // Drives raw_det to lvl and checks det_qual moves on exactly the nth edge.
    task automatic edge_len(string req, logic lvl, int n);
        raw_det = lvl;
        repeat (n - 1) @(negedge clk);
        if (n > 1) check(req, {15'b0, det_qual}, {15'b0, ~lvl});
        @(negedge clk);
        check(req, {15'b0, det_qual}, {15'b0, lvl});
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        rd_check("R1 word", 8'h0A, 16'h0000);
        check("R1 outs", {12'b0, scr_active, loop_sel, det_qual, tx_off}, 16'h0000);
        do_reset(1'b1);
        rd_check("R1 strap word", 8'h0A, 16'h0001);
        strap_scr = 1'b0;
        do_reset(1'b0);
    endtask

    task automatic t_regs();
        wr_word(16'hFFFF);
        rd_check("R3 mask", 8'h0A, 16'h3FC3);
        rd_check("R2 other addr", 8'h0B, 16'h0000);
        wr_word(16'h1542);
        rd_check("R2 readback", 8'h0A, 16'h1542);
        wr_word(16'h0002);
        check("R5 loop on", {15'b0, loop_sel}, 16'h1);
        wr_word(16'h0000);
        check("R5 loop off", {15'b0, loop_sel}, 16'h0);
    endtask

    task automatic t_strap();
        strap_scr = 1'b1;
        #1 check("R4 active", {15'b0, scr_active}, 16'h1);
        @(negedge clk);
        wr_word(16'h0000);
        rd_check("R4 forced", 8'h0A, 16'h0001);
        strap_scr = 1'b0;
        @(negedge clk);
        wr_word(16'h0000);
        rd_check("R4 cleared", 8'h0A, 16'h0000);
        check("R4 inactive", {15'b0, scr_active}, 16'h0);
        wr_word(16'h0001);
        rd_check("R4 sw set", 8'h0A, 16'h0001);
    endtask

    task automatic t_pass();
        wr_word(16'h3CC0);               // enables set, scrambling off
        edge_len("R6 off rise", 1'b1, 1);
        edge_len("R6 off fall", 1'b0, 1);
        wr_word(16'h0001);               // active, enables clear
        edge_len("R6 en clr rise", 1'b1, 1);
        edge_len("R6 en clr fall", 1'b0, 1);
    endtask

    task automatic t_rise(logic [1:0] code, int n);
        wr_word(16'h0001);
        raw_det = 1'b0;
        repeat (3) @(negedge clk);
        wr_word(16'h0081 | (16'(code) << 10));
        edge_len("R7 rise delay", 1'b1, n);
    endtask

    task automatic t_fall(logic [1:0] code, int n);
        wr_word(16'h0001);
        raw_det = 1'b1;
        repeat (3) @(negedge clk);
        wr_word(16'h0041 | (16'(code) << 12));
        edge_len("R8 fall delay", 1'b0, n);
    endtask

    task automatic t_glitch();
        wr_word(16'h0001);
        raw_det = 1'b0;
        repeat (3) @(negedge clk);
        wr_word(16'h00C1);               // rise 21, fall 19
        raw_det = 1'b1;
        repeat (15) @(negedge clk);
        raw_det = 1'b0;
        @(negedge clk);
        check("R9 rise glitch", {15'b0, det_qual}, 16'h0);
        edge_len("R9 rise restart", 1'b1, 21);
        raw_det = 1'b0;
        repeat (10) @(negedge clk);
        raw_det = 1'b1;
        @(negedge clk);
        check("R9 fall glitch", {15'b0, det_qual}, 16'h1);
        edge_len("R9 fall restart", 1'b0, 19);
    endtask

    task automatic t_tx(logic [1:0] code, int n);
        wr_word(16'h0001 | (16'(code) << 8));
        quiet_tx = 1'b0;
        repeat (2) @(negedge clk);
        quiet_tx = 1'b1;
        if (n == 0) begin
            #1 check("R10 immediate", {15'b0, tx_off}, 16'h1);
        end else if (n < 0) begin
            repeat (1300) @(negedge clk);
            check("R10 never", {15'b0, tx_off}, 16'h0);
        end else begin
            repeat (n - 1) @(negedge clk);
            check("R10 before delay", {15'b0, tx_off}, 16'h0);
            @(negedge clk);
            check("R10 at delay", {15'b0, tx_off}, 16'h1);
        end
        quiet_tx = 1'b0;
        #1 check("R11 drop", {15'b0, tx_off}, 16'h0);
        @(negedge clk);
    endtask

    task automatic t_tx_inactive();
        wr_word(16'h0300);
        quiet_tx = 1'b1;
        #1 check("R11 inactive follow", {15'b0, tx_off}, 16'h1);
        @(negedge clk);
        quiet_tx = 1'b0;
        #1 check("R11 inactive low", {15'b0, tx_off}, 16'h0);
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_regs();
        t_strap();
        t_pass();
        t_rise(2'b00, 21);
        t_rise(2'b01, 33);
        t_rise(2'b10, 63);
        t_rise(2'b11, 128);
        t_fall(2'b00, 19);
        t_fall(2'b01, 33);
        t_fall(2'b10, 63);
        t_fall(2'b11, 128);
        t_glitch();
        t_tx(2'b00, 0);
        t_tx(2'b01, 750);
        t_tx(2'b10, 1250);
        t_tx(2'b11, -1);
        t_tx_inactive();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule